// File: doc/BRIEF.md
# Power-On Fail-Safe Fan Sequencer

This block decides how fan control starts after power-up. In the first clock cycle after reset it samples a comparator that reports whether the processor supply rail is powered. If the rail is unpowered it waits, with no time limit, for a host to reach the device over the serial management bus. Once a host arrives it loads the default register settings and enters normal operation.

If the rail is powered, a fail-safe countdown starts. A host transaction that arrives before the countdown ends leads straight to the defaults and normal operation. If the countdown ends first, the fans are forced to full speed and stay there until a host appears. A late host first switches the fans off for one cycle, then the defaults are loaded, then normal operation begins. Normal operation is terminal, and only reset leaves it.

The bus decoder that produces the transaction pulse and the fan PWM generators sit outside this block. The timeout is a parameter counted in clock cycles. At 100 MHz the default value of 460,000,000 cycles gives 4.6 s.

Top module: `fan_boot_seq`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, and in the cycle after reset is released, `fan_full`, `fan_off`, `load_dflt` and `run_normal` are all 0.
- R2: If `rail_ok` is 0 at the first rising edge after reset release, no countdown runs. `fan_full` never rises however long the wait lasts, and later changes of `rail_ok` have no effect.
- R3: While waiting with the rail unpowered, a `bus_hit` pulse makes `load_dflt` 1 after the next edge. `run_normal` is 1 one cycle later.
- R4: If `rail_ok` is 1 and `bus_hit` is 0 at the first edge after reset release, and `bus_hit` stays 0, then `fan_full` becomes 1 after edge number TIMEOUT_CYC+1, counting that first edge as number 1. It is 0 before that edge.
- R5: A `bus_hit` during the countdown, including its final cycle, produces `load_dflt` after the next edge and then `run_normal`. `fan_full` does not rise.
- R6: Once `fan_full` is 1, it stays 1 while `bus_hit` is 0. At most one of the four outputs is 1 at any time.
- R7: A `bus_hit` while `fan_full` is 1 gives `fan_off`=1 for exactly one cycle after the next edge. This is followed by `load_dflt` for one cycle and then `run_normal`.
- R8: `load_dflt` is a single-cycle pulse issued exactly once per reset. Further `bus_hit` pulses do not produce another.
- R9: `run_normal` stays 1, and the other outputs stay 0, regardless of `rail_ok` and `bus_hit`, until reset is asserted. Reset clears it at once.
- R10: A `bus_hit` at the first edge after reset release produces `load_dflt` after that edge, whatever the value of `rail_ok`.
- R11: `rail_ok` is sampled only at the first edge. Changes to it during the countdown neither stop nor restart the countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rail_ok | input | 1 | Processor rail above its power-good threshold |
| bus_hit | input | 1 | One-cycle pulse for each valid host transaction |
| fan_full | output | 1 | Force the fans to full speed |
| fan_off | output | 1 | Switch the fans off |
| load_dflt | output | 1 | One-cycle strobe that loads the default registers |
| run_normal | output | 1 | Normal operation has begun |

## Verification
The bench places a host pulse in the final countdown cycle. A design that lets the timer win that tie would force the fans to full speed when it should load the defaults. The bench waits far longer than the timeout with the rail unpowered, which exposes a design that runs the timer on both paths. It toggles the rail during the countdown to catch a design that resamples it. It also sends repeated host pulses after normal operation has begun. A design that skips the fans-off cycle, strobes the defaults more than once, or falls out of normal operation would show the wrong output sequence or a second strobe.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [2:0] {
    ST_SAMPLE = 3'd0,
    ST_WAIT   = 3'd1,
    ST_COUNT  = 3'd2,
    ST_FULL   = 3'd3,
    ST_OFF    = 3'd4,
    ST_LOAD   = 3'd5,
    ST_NORMAL = 3'd6
  } fbs_state_e;

  // Output bundle order: {full, off, load, normal}
  function automatic logic [3:0] fan_outputs(input fbs_state_e s);
    logic [3:0] o;
    o = 4'b0000;
    case (s)
      ST_FULL:   o = 4'b1000;
      ST_OFF:    o = 4'b0100;
      ST_LOAD:   o = 4'b0010;
      ST_NORMAL: o = 4'b0001;
      default:   o = 4'b0000;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/fbs_timer.sv
module fbs_timer #(
  parameter int unsigned TIMEOUT_CYC = 460_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic reached(input logic [CW-1:0] c);
    return c == LAST;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= bump(cnt);
    else          cnt <= '0;
  end

  assign done = run && reached(cnt);

  // R4: the count is at zero in the first cycle of every run
  a_r4_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt == '0);

endmodule

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
  import fbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rail_ok,
  input  logic       bus_hit,
  input  logic       tmr_done,
  output logic       tmr_run,
  output fbs_state_e state
);
  fbs_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_SAMPLE: begin
        if (bus_hit)      nxt = ST_LOAD;
        else if (rail_ok) nxt = ST_COUNT;
        else              nxt = ST_WAIT;
      end
      ST_WAIT:   if (bus_hit) nxt = ST_LOAD;
      ST_COUNT: begin
        if (bus_hit)       nxt = ST_LOAD;
        else if (tmr_done) nxt = ST_FULL;
      end
      ST_FULL:   if (bus_hit) nxt = ST_OFF;
      ST_OFF:    nxt = ST_LOAD;
      ST_LOAD:   nxt = ST_NORMAL;
      ST_NORMAL: nxt = ST_NORMAL;
      default:   nxt = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SAMPLE;
    else        state <= nxt;
  end

  assign tmr_run = (state == ST_COUNT);

  // R2: the unpowered-rail wait never times out
  a_r2_wait_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WAIT |=> (state == ST_WAIT || state == ST_LOAD));

  // R5: a host during the countdown wins, even against expiry
  a_r5_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && bus_hit) |=> state == ST_LOAD);

  // R11: the rail value does not disturb a running countdown
  a_r11_rail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && !bus_hit && !tmr_done) |=> state == ST_COUNT);

endmodule

// File: rtl/fbs_outdec.sv
module fbs_outdec
  import fbs_pkg::*;
(
  input  fbs_state_e state,
  output logic       fan_full,
  output logic       fan_off,
  output logic       load_dflt,
  output logic       run_normal
);
  assign {fan_full, fan_off, load_dflt, run_normal} = fan_outputs(state);
endmodule

// File: rtl/fan_boot_seq.sv
module fan_boot_seq
  import fbs_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 460_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_ok,
  input  logic bus_hit,
  output logic fan_full,
  output logic fan_off,
  output logic load_dflt,
  output logic run_normal
);
  fbs_state_e state;
  logic       tmr_run;
  logic       tmr_done;

  fbs_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tmr_run),
    .done (tmr_done)
  );

  fbs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rail_ok (rail_ok),
    .bus_hit (bus_hit),
    .tmr_done(tmr_done),
    .tmr_run (tmr_run),
    .state   (state)
  );

  fbs_outdec u_dec (
    .state     (state),
    .fan_full  (fan_full),
    .fan_off   (fan_off),
    .load_dflt (load_dflt),
    .run_normal(run_normal)
  );

  // Records whether the strobe has been seen (used only by the checks)
  logic load_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         load_seen <= 1'b0;
    else if (load_dflt) load_seen <= 1'b1;
  end

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fan_full, fan_off, load_dflt, run_normal}));

  a_r4_full_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fan_full) |-> $past(tmr_done));

  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_full && !bus_hit) |=> fan_full);

  a_r7_off_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    fan_off |=> load_dflt);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_dflt |=> (!load_dflt && run_normal));

  a_r8_only_once: assert property (@(posedge clk) disable iff (!rst_n)
    load_dflt |-> !load_seen);

  a_r9_normal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_normal |=> run_normal);

endmodule

// File: tb/sim_fan_boot_seq.sv
`timescale 1ns/1ps
module sim_fan_boot_seq;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail_ok = 1'b0;
  logic bus_hit = 1'b0;
  logic fan_full, fan_off, load_dflt, run_normal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fan_boot_seq #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .bus_hit(bus_hit),
    .fan_full(fan_full), .fan_off(fan_off), .load_dflt(load_dflt),
    .run_normal(run_normal)
  );

  always #2 clk = ~clk;

  // Row: {req, rst_n, rail_ok, bus_hit, expected {full, off, load, normal}}
  // Each row drives its inputs, waits one edge, then compares.
  localparam logic [10:0] VEC [37] = '{
    // timeout path (TO = 6), then a late host
    {4'd1,  3'b000, 4'b0000},  // R1
    {4'd4,  3'b110, 4'b0000},  // R4 first edge
    {4'd11, 3'b100, 4'b0000},  // R11 rail toggles
    {4'd11, 3'b110, 4'b0000},
    {4'd11, 3'b100, 4'b0000},
    {4'd11, 3'b100, 4'b0000},
    {4'd11, 3'b110, 4'b0000},
    {4'd4,  3'b100, 4'b1000},  // R4 edge TO+1
    {4'd6,  3'b110, 4'b1000},  // R6 held
    {4'd7,  3'b101, 4'b0100},  // R7 late host
    {4'd7,  3'b100, 4'b0010},
    {4'd8,  3'b100, 4'b0001},
    {4'd9,  3'b101, 4'b0001},  // R9 extra hit
    // unpowered rail waits past the timeout
    {4'd1,  3'b000, 4'b0000},
    {4'd2,  3'b100, 4'b0000},  // R2
    {4'd2,  3'b110, 4'b0000},
    {4'd2,  3'b100, 4'b0000},
    {4'd2,  3'b110, 4'b0000},
    {4'd2,  3'b100, 4'b0000},
    {4'd2,  3'b110, 4'b0000},
    {4'd2,  3'b100, 4'b0000},
    {4'd2,  3'b110, 4'b0000},
    {4'd2,  3'b100, 4'b0000},
    {4'd3,  3'b101, 4'b0010},  // R3
    {4'd3,  3'b100, 4'b0001},
    // host in the last countdown cycle
    {4'd1,  3'b000, 4'b0000},
    {4'd5,  3'b110, 4'b0000},  // R5
    {4'd5,  3'b100, 4'b0000},
    {4'd5,  3'b100, 4'b0000},
    {4'd5,  3'b100, 4'b0000},
    {4'd5,  3'b100, 4'b0000},
    {4'd5,  3'b100, 4'b0000},
    {4'd5,  3'b101, 4'b0010},
    {4'd5,  3'b100, 4'b0001},
    // host at the first edge
    {4'd1,  3'b000, 4'b0000},
    {4'd10, 3'b111, 4'b0010},  // R10
    {4'd10, 3'b100, 4'b0001}
  };

  task automatic chk(input int req, input logic [3:0] exp);
    logic [3:0] got;
    got = {fan_full, fan_off, load_dflt, run_normal};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: outputs %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_val(input int req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL R%0d: value %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_hit = 1'b0;
    tick();
    rst_n = 1'b1;
  endtask

  initial begin
    logic [3:0] req;
    logic [3:0] exp;
    int n, loads, offs, fulls;

    for (int i = 0; i < 37; i++) begin
      {req, rst_n, rail_ok, bus_hit, exp} = VEC[i];
      tick();
      chk(int'(req), exp);
    end

    // R4: count edges to full speed independently
    rail_ok = 1'b1;
    do_reset();
    n = 0;
    for (int k = 0; k < 100 && !fan_full; k++) begin
      tick();
      n++;
      if (k == 0) rail_ok = 1'b0;
    end
    chk_val(4, n, TO + 1);
    // R6: hold for a long time
    fulls = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (fan_full) fulls++; end
    chk_val(6, fulls, 30);
    // R7 and R8: one off cycle, exactly one strobe
    bus_hit = 1'b1; tick(); bus_hit = 1'b0;
    loads = 0; offs = int'(fan_off);
    for (int k = 0; k < 12; k++) begin
      if (load_dflt) loads++;
      tick();
      if (fan_off) offs++;
      if (k % 3 == 0) bus_hit = 1'b1; else bus_hit = 1'b0;
    end
    bus_hit = 1'b0;
    chk_val(7, offs, 1);
    chk_val(8, loads, 1);
    chk(9, 4'b0001);  // R9 still normal after extra hits
    // R9 and R1: asynchronous reset leaves normal immediately
    rst_n = 1'b0; #1;
    chk(9, 4'b0000);
    tick();
    chk(1, 4'b0000);

    // R2: long unpowered wait, rail rises midway
    rail_ok = 1'b0;
    rst_n = 1'b1;
    fulls = 0;
    for (int k = 0; k < 60; k++) begin
      tick();
      if (k == 20) rail_ok = 1'b1;
      if (fan_full) fulls++;
    end
    chk_val(2, fulls, 0);
    bus_hit = 1'b1; tick(); bus_hit = 1'b0;
    chk(3, 4'b0010);
    tick();
    chk(3, 4'b0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule